// File: doc/BRIEF.md
# Packed Unsigned-by-Signed Byte Pair Multiply-Add Unit

This block is a SIMD datapath for a vector execution unit. It takes two packed byte vectors of up to 512 bits. Every byte of the first vector is read as unsigned and every byte of the second as signed. Each byte is multiplied by its partner in the other vector. The two products from each adjacent byte pair are added, and the sum is clamped into a signed 16-bit word. The result is a packed vector of words, one word for each byte pair.

The active vector length can be 64, 128, 256 or 512 bits. An optional per-word write mask chooses which words take the new result. A word left unselected either keeps the previous destination value or is cleared, as the merge/zero select decides. Destination bits above the active length are cleared. The one exception is legacy keep mode, used when no mask is applied, in which those bits keep their previous content.

With the default parameters the result is registered. It appears, together with a valid flag, one clock after the operands are presented.

Top module: `bytepair_madd`

## Requirements
- R1: Result word k (bits 16k+15:16k) equals the product of unsigned byte 2k of `src_u` and signed byte 2k of `src_s`, plus the product of unsigned byte 2k+1 of `src_u` and signed byte 2k+1 of `src_s`. Byte n occupies bits 8n+7:8n.
- R2: A pair sum greater than 32767 is written as 32767 (16'h7FFF). For example, two pairs of 255 and 127 give 64770, which is written as 32767.
- R3: A pair sum less than -32768 is written as -32768 (16'h8000). For example, two pairs of 255 and -128 give -65280, which is written as -32768.
- R4: `vlen_sel` sets the number of active words: 0 gives 4 words (64 bits), 1 gives 8, 2 gives 16 and 3 gives 32 (512 bits). Words 0 up to (active count - 1) are the active ones.
- R5: When `mask_en` is 0, every active word takes its new result, whatever the value of `wmask`.
- R6: When `mask_en` is 1, an active word j whose `wmask[j]` is 1 takes its new result. If `wmask[j]` is 0 and `zero_mode` is 0, the word takes word j of `dest_old`.
- R7: When `mask_en` is 1 and `zero_mode` is 1, an active word whose mask bit is 0 is written as zero.
- R8: Result bits above the active length are zero. The exception is `legacy_keep` = 1 together with `mask_en` = 0: then those bits equal the matching bits of `dest_old`. Mask bits of inactive words have no effect.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` then carries that operation's value and holds it through the cycles that follow without `in_valid`.
- R10: After reset, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| vlen_sel | input | 2 | Active length: 0=64, 1=128, 2=256, 3=512 bits |
| legacy_keep | input | 1 | Keep destination bits above the active length when unmasked |
| mask_en | input | 1 | Apply the per-word write mask |
| zero_mode | input | 1 | Unselected words: 1 = clear, 0 = keep old value |
| wmask | input | 32 | Per-word write mask, bit j for word j |
| src_u | input | 512 | Unsigned byte operand vector |
| src_s | input | 512 | Signed byte operand vector |
| dest_old | input | 512 | Previous destination value |
| out_valid | output | 1 | Result register holds a new operation |
| result | output | 512 | Packed signed word result |

## Verification
Every result lands in the output register at the first rising edge after `in_valid` is sampled, so it is due one clock after the operands. The bench drives the operands on a falling edge and deasserts `in_valid` on the next falling edge. It compares `out_valid` and every word at that same falling edge, half a cycle after the capturing edge. Hold behaviour is checked one further falling edge later, after the operands have been changed with `in_valid` low. The sweep puts every unsigned-by-signed pair into the low byte lanes, and 128 further vectors cover all masking, length and legacy combinations.

// File: rtl/bpm_pkg.sv
`timescale 1ns/1ps
package bpm_pkg;

    typedef enum logic [1:0] {
        VL_64  = 2'd0,
        VL_128 = 2'd1,
        VL_256 = 2'd2,
        VL_512 = 2'd3
    } vlen_e;

    // Number of result words enabled by a length code, the widest code
    // enabling all `total` words and each smaller code halving it.
    function automatic int active_words(input logic [1:0] sel, input int total);
        int shift;
        shift = 3 - int'(sel);
        return total >> shift;
    endfunction

endpackage

// File: rtl/bpm_lane.sv
`timescale 1ns/1ps
// One result word: two unsigned x signed byte products, summed and clamped.
module bpm_lane #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]   u_lo,
    input  logic [BYTE_W-1:0]   u_hi,
    input  logic [BYTE_W-1:0]   s_lo,
    input  logic [BYTE_W-1:0]   s_hi,
    output logic [2*BYTE_W-1:0] word_o
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PROD_W = 2 * BYTE_W + 1;   // 9-bit x 8-bit signed product
    localparam int SUM_W  = PROD_W + 1;       // one growth bit for the pair sum
    localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << (WORD_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(1 << (WORD_W - 1));

    logic signed [PROD_W-1:0] ue_lo, ue_hi, se_lo, se_hi;
    logic signed [PROD_W-1:0] prod_lo, prod_hi;
    logic signed [SUM_W-1:0]  pair_sum;

    always_comb begin
        ue_lo = {{(PROD_W-BYTE_W){1'b0}}, u_lo};
        ue_hi = {{(PROD_W-BYTE_W){1'b0}}, u_hi};
        se_lo = {{(PROD_W-BYTE_W){s_lo[BYTE_W-1]}}, s_lo};
        se_hi = {{(PROD_W-BYTE_W){s_hi[BYTE_W-1]}}, s_hi};
        prod_lo = ue_lo * se_lo;
        prod_hi = ue_hi * se_hi;
        pair_sum = {prod_lo[PROD_W-1], prod_lo} + {prod_hi[PROD_W-1], prod_hi};
        if (pair_sum > MAX_V) begin
            word_o = MAX_V[WORD_W-1:0];
        end else if (pair_sum < MIN_V) begin
            word_o = MIN_V[WORD_W-1:0];
        end else begin
            word_o = pair_sum[WORD_W-1:0];
        end
    end

endmodule

// File: rtl/bpm_wordsel.sv
`timescale 1ns/1ps
// Per-word write selection: mask, merge/zero and above-length handling.
module bpm_wordsel #(
    parameter int WORD_W = 16,
    parameter int NWORDS = 32
) (
    input  logic [NWORDS*WORD_W-1:0] fresh_i,
    input  logic [NWORDS*WORD_W-1:0] old_i,
    input  logic [NWORDS-1:0]        active_i,
    input  logic [NWORDS-1:0]        wmask_i,
    input  logic                     mask_en_i,
    input  logic                     zero_mode_i,
    input  logic                     legacy_keep_i,
    output logic [NWORDS*WORD_W-1:0] merged_o
);
    logic keep_upper;
    assign keep_upper = legacy_keep_i & ~mask_en_i;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [WORD_W-1:0] fresh_w, old_w, out_w;
        assign fresh_w = fresh_i[g*WORD_W +: WORD_W];
        assign old_w   = old_i[g*WORD_W +: WORD_W];
        always_comb begin
            if (!active_i[g]) begin
                out_w = keep_upper ? old_w : '0;
            end else if (!mask_en_i || wmask_i[g]) begin
                out_w = fresh_w;
            end else begin
                out_w = zero_mode_i ? '0 : old_w;
            end
        end
        assign merged_o[g*WORD_W +: WORD_W] = out_w;
    end

endmodule

// File: rtl/bytepair_madd.sv
`timescale 1ns/1ps
module bytepair_madd #(
    parameter int MAX_BITS = 512,
    parameter int BYTE_W   = 8,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [1:0]                         vlen_sel,
    input  logic                               legacy_keep,
    input  logic                               mask_en,
    input  logic                               zero_mode,
    input  logic [MAX_BITS/(2*BYTE_W)-1:0]     wmask,
    input  logic [MAX_BITS-1:0]                src_u,
    input  logic [MAX_BITS-1:0]                src_s,
    input  logic [MAX_BITS-1:0]                dest_old,
    output logic                               out_valid,
    output logic [MAX_BITS-1:0]                result
);
    import bpm_pkg::*;

    localparam int WORD_W    = 2 * BYTE_W;
    localparam int NWORDS    = MAX_BITS / WORD_W;
    localparam int MIN_WORDS = NWORDS / 8;
    localparam int MIN_BITS  = MIN_WORDS * WORD_W;

    typedef struct packed {
        logic                vld;
        logic [MAX_BITS-1:0] data;
    } out_st_t;

    logic [MAX_BITS-1:0] fresh;
    logic [MAX_BITS-1:0] merged;
    logic [NWORDS-1:0]   active;
    int                  n_active;

    always_comb begin
        n_active = active_words(vlen_sel, NWORDS);
        for (int j = 0; j < NWORDS; j++) begin
            active[j] = (j < n_active);
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_lane
        bpm_lane #(.BYTE_W(BYTE_W)) u_lane (
            .u_lo   (src_u[g*WORD_W +: BYTE_W]),
            .u_hi   (src_u[g*WORD_W+BYTE_W +: BYTE_W]),
            .s_lo   (src_s[g*WORD_W +: BYTE_W]),
            .s_hi   (src_s[g*WORD_W+BYTE_W +: BYTE_W]),
            .word_o (fresh[g*WORD_W +: WORD_W])
        );
    end

    bpm_wordsel #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_sel (
        .fresh_i       (fresh),
        .old_i         (dest_old),
        .active_i      (active),
        .wmask_i       (wmask),
        .mask_en_i     (mask_en),
        .zero_mode_i   (zero_mode),
        .legacy_keep_i (legacy_keep),
        .merged_o      (merged)
    );

    out_st_t st_d, st_q;

    if (REG_OUT) begin : g_reg
        always_comb begin
            st_d     = st_q;
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.data = merged;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R9
        AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid); // R9
        AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result)); // R9
        AST_ZERO_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mask_en && zero_mode && !wmask[0]) |=> (result[WORD_W-1:0] == '0)); // R7
        AST_MERGE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mask_en && !zero_mode && !wmask[0])
            |=> (result[WORD_W-1:0] == $past(dest_old[WORD_W-1:0]))); // R6
        AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && vlen_sel == 2'd0 && !(legacy_keep && !mask_en))
            |=> (result[MAX_BITS-1:MIN_BITS] == '0)); // R8
        AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && vlen_sel == 2'd0 && legacy_keep && !mask_en)
            |=> (result[MAX_BITS-1:MIN_BITS] == $past(dest_old[MAX_BITS-1:MIN_BITS]))); // R8
    end else begin : g_comb
        always_comb begin
            st_d.vld  = in_valid;
            st_d.data = merged;
        end
        assign st_q = st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.data;

endmodule

// File: tb/bytepair_madd_tb_top.sv
`timescale 1ns/1ps
module bytepair_madd_tb_top;

    localparam int NB = 512;
    localparam int NW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] vlen_sel = 2'd3;
    logic legacy_keep = 1'b0;
    logic mask_en = 1'b0;
    logic zero_mode = 1'b0;
    logic [NW-1:0] wmask = '0;
    logic [NB-1:0] src_u = '0;
    logic [NB-1:0] src_s = '0;
    logic [NB-1:0] dest_old = '0;
    logic out_valid;
    logic [NB-1:0] result;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    bytepair_madd dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
        .legacy_keep(legacy_keep), .mask_en(mask_en), .zero_mode(zero_mode),
        .wmask(wmask), .src_u(src_u), .src_s(src_s), .dest_old(dest_old),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] rnd32();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [NB-1:0] rnd_vec();
        logic [NB-1:0] v;
        for (int i = 0; i < NB / 32; i++) v[i*32 +: 32] = rnd32();
        return v;
    endfunction

    // Arithmetic reference built from the requirements.
    function automatic logic [NB-1:0] model();
        logic [NB-1:0] r;
        int nact;
        nact = 4 << vlen_sel;
        for (int j = 0; j < NW; j++) begin
            int ua0, ua1, sb0, sb1, sum;
            logic [15:0] w;
            ua0 = int'(src_u[16*j +: 8]);
            ua1 = int'(src_u[16*j+8 +: 8]);
            sb0 = int'($signed(src_s[16*j +: 8]));
            sb1 = int'($signed(src_s[16*j+8 +: 8]));
            sum = ua0 * sb0 + ua1 * sb1;
            if (sum > 32767) sum = 32767;
            if (sum < -32768) sum = -32768;
            w = sum[15:0];
            if (j >= nact) begin
                r[16*j +: 16] = (legacy_keep && !mask_en) ? dest_old[16*j +: 16] : 16'h0;
            end else if (!mask_en || wmask[j]) begin
                r[16*j +: 16] = w;
            end else begin
                r[16*j +: 16] = zero_mode ? 16'h0 : dest_old[16*j +: 16];
            end
        end
        return r;
    endfunction

    task automatic check_bits(string tag, string what, logic [NB-1:0] act, logic [NB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(string tag);
        logic [NB-1:0] exp;
        @(negedge clk);
        in_valid = 1'b1;
        exp = model();
        @(negedge clk);
        in_valid = 1'b0;
        check_bits("R9", "out_valid", NB'(out_valid), NB'(1));
        for (int j = 0; j < NW; j++) begin
            n_checks++;
            if (result[16*j +: 16] !== exp[16*j +: 16]) begin
                n_fail++;
                $display("FAIL %s word %0d: actual %h expected %h", tag, j,
                         result[16*j +: 16], exp[16*j +: 16]);
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [NB-1:0] held;
        repeat (3) @(negedge clk);
        check_bits("R10", "reset out_valid", NB'(out_valid), '0);
        check_bits("R10", "reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bits("R10", "post-reset idle", result, '0);

        // R1/R2/R3: every unsigned x signed pair in the low lanes, full length, unmasked.
        vlen_sel = 2'd3;
        for (int v = 0; v < 2048; v++) begin
            for (int j = 0; j < NW; j++) begin
                logic [15:0] n;
                logic [31:0] x;
                n = 16'(v * NW + j);
                x = rnd32();
                src_u[16*j +: 8] = n[15:8];
                src_s[16*j +: 8] = n[7:0];
                src_u[16*j+8 +: 8] = x[7:0];
                src_s[16*j+8 +: 8] = x[15:8];
            end
            dest_old = rnd_vec();
            wmask = rnd32();
            run_vec("R1");
        end

        // R2: 255*127 pairs saturate high.
        src_u = {64{8'hFF}};
        src_s = {64{8'h7F}};
        run_vec("R2");
        check_bits("R2", "sat high word0", NB'(result[15:0]), NB'(16'h7FFF));
        // R3: 255*-128 pairs saturate low.
        src_s = {64{8'h80}};
        run_vec("R3");
        check_bits("R3", "sat low word0", NB'(result[15:0]), NB'(16'h8000));

        // R4..R8: every length / legacy / mask / zero combination.
        for (int c = 0; c < 32; c++) begin
            vlen_sel    = c[1:0];
            legacy_keep = c[2];
            mask_en     = c[3];
            zero_mode   = c[4];
            for (int k = 0; k < 4; k++) begin
                src_u = rnd_vec();
                src_s = rnd_vec();
                dest_old = rnd_vec();
                wmask = rnd32();
                if (!mask_en) run_vec("R5");
                else if (zero_mode) run_vec("R7");
                else run_vec("R6");
                if (vlen_sel != 2'd3) run_vec("R8");
                else run_vec("R4");
            end
        end

        // R9: result holds and valid drops while in_valid stays low.
        held = result;
        src_u = rnd_vec();
        src_s = rnd_vec();
        dest_old = rnd_vec();
        @(negedge clk);
        check_bits("R9", "hold result", result, held);
        check_bits("R9", "valid low", NB'(out_valid), '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule